// File: doc/BRIEF.md
# Ordering Table Clear Engine

This engine fills a region of memory with a backward-linked chain of word pointers, a structure that a later list-walking transfer consumes. Software programs a starting byte address and a word count, then sets two control bits: an enable that stays set for the whole transfer, and a trigger that acts as the request. When a global enable input is also high, the engine issues one memory write for each word. It walks downward from the start address, and every word except the last holds the address of the word just below it. The last word holds the end-of-chain value 0x00FFFFFF.

The engine produces its data internally. No device port is involved. Addresses are kept within a power-of-two memory space set by a parameter, so a chain that runs below address zero wraps to the top of that space. When the final write is accepted, the enable bit drops and a one-cycle completion pulse goes to the interrupt logic.

Top module: `chain_clear_engine`

## Requirements
- R1: After reset the start, count and control registers read zero, no memory write is issued and `done_o` is low.
- R2: Register select 0 holds the start address and keeps only bits 23:0. Select 1 holds the word count and keeps only bits 15:0. Select 2 is control: bit 0 is enable/busy and bit 1 is trigger, and its other bits read zero. Select 3 reads zero.
- R3: A transfer begins only when `master_en_i`, the enable bit and the trigger bit are all high. If any one of them is low, no write is issued.
- R4: The trigger bit clears when the transfer begins. The enable bit stays set throughout the transfer and clears when the final write is accepted.
- R5: The first write goes to the start address with bits 1:0 cleared and bits above the memory size cleared. Each later write goes 4 bytes lower, wrapping within the memory size.
- R6: Every write other than the last carries its own address minus 4, wrapped within the memory size.
- R7: A count of N from 1 to 65535 gives exactly N writes, and the last write carries 0x00FFFFFF.
- R8: A count of 0 gives 65536 writes.
- R9: While `mem_ready_i` is low, the pending write holds its address and data and the chain does not advance.
- R10: `done_o` is high for exactly one cycle, the cycle after the final write is accepted. No write is issued in that cycle.
- R11: A control write during a transfer changes only the trigger bit. It leaves the enable bit set and does not restart or stop the engine. Writes to the start address or count during a transfer do not alter the chain being written.
- R12: With `mem_ready_i` held high, writes are issued on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select for writes and reads |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| master_en_i | input | 1 | Global enable for this channel |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| mem_we_o | output | 1 | Memory write valid |
| mem_addr_o | output | 24 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Word to write |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The bench sweeps counts from one to nine across start addresses that are aligned, unaligned, above the memory size and close enough to zero to wrap, with and without write back-pressure. A design that fails to mask, align or wrap the address writes a chain that points outside memory. An off-by-one in the count loses the end-of-chain word or writes one extra word. A count of zero is driven to show that it means a full 65536-word chain rather than an idle or single-word transfer. Control, start-address and count writes are placed in the middle of a transfer to catch an engine that restarts, stops early or picks up the new values.

// File: rtl/cce_pkg.sv
package cce_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] END_MARK = 24'hFFFFFF;
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_TRIG_BIT = 1;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE,
    ST_FILL
  } walk_st_e;
endpackage

// File: rtl/cce_regs.sv
module cce_regs
  import cce_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  input  logic              start_i,
  input  logic              finish_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              run_o,
  output logic              trig_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  count_q;
  logic              run_q, trig_q;
  logic              ctrl_wr;

  assign ctrl_wr = we_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      count_q <= '0;
      run_q   <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      if (we_i && sel_i == SEL_BASE)  base_q  <= wdata_i[ADDR_W-1:0];
      if (we_i && sel_i == SEL_COUNT) count_q <= wdata_i[CNT_W-1:0];
      // enable bit is locked while the walker owns it
      if (finish_i)                 run_q <= 1'b0;
      else if (ctrl_wr && !active_i) run_q <= wdata_i[CTRL_RUN_BIT];
      if (start_i)      trig_q <= 1'b0;
      else if (ctrl_wr) trig_q <= wdata_i[CTRL_TRIG_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_BASE:  rdata_o[ADDR_W-1:0] = base_q;
      SEL_COUNT: rdata_o[CNT_W-1:0]  = count_q;
      SEL_CTRL: begin
        rdata_o[CTRL_RUN_BIT]  = run_q;
        rdata_o[CTRL_TRIG_BIT] = trig_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign base_o  = base_q;
  assign count_o = count_q;
  assign run_o   = run_q;
  assign trig_o  = trig_q;
endmodule

// File: rtl/cce_walker.sv
module cce_walker
  import cce_pkg::*;
#(
  parameter int unsigned MEM_AW = 21,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic              run_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              mem_ready_i,
  output logic              start_o,
  output logic              finish_o,
  output logic              active_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o
);
  localparam int unsigned LEN_W = CNT_W + 1;
  localparam logic [ADDR_W-1:0] SPACE_MASK = ADDR_W'((64'd1 << MEM_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = SPACE_MASK & ~ADDR_W'(3);

  walk_st_e          st_q;
  logic [ADDR_W-1:0] cur_q, next_addr;
  logic [LEN_W-1:0]  left_q, len_init;
  logic              done_q, last_w, accept;

  // count of zero stands for the full 2**CNT_W words
  assign len_init  = (count_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_i};
  assign next_addr = (cur_q - ADDR_W'(4)) & SPACE_MASK;
  assign last_w    = (left_q == LEN_W'(1));
  assign accept    = (st_q == ST_FILL) && mem_ready_i;

  assign start_o     = (st_q == ST_IDLE) && master_en_i && run_i && trig_i;
  assign finish_o    = accept && last_w;
  assign active_o    = (st_q == ST_FILL);
  assign mem_we_o    = (st_q == ST_FILL);
  assign mem_addr_o  = cur_q;
  assign mem_wdata_o = {{(DATA_W-ADDR_W){1'b0}}, (last_w ? END_MARK : next_addr)};
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_o;
      if (start_o) begin
        st_q   <= ST_FILL;
        cur_q  <= base_i & ALIGN_MASK;
        left_q <= len_init;
      end else if (accept) begin
        cur_q  <= next_addr;
        left_q <= left_q - LEN_W'(1);
        if (last_w) st_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/chain_clear_engine.sv
module chain_clear_engine
  import cce_pkg::*;
#(
  parameter int unsigned MEM_AW = 21,
  parameter int unsigned CNT_W  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        master_en_i,
  input  logic        mem_ready_i,
  output logic        mem_we_o,
  output logic [23:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        done_o
);
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  count;
  logic              run, trig, start, finish, active;

  cce_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_e'(reg_addr_i)),
    .wdata_i  (reg_wdata_i),
    .active_i (active),
    .start_i  (start),
    .finish_i (finish),
    .base_o   (base),
    .count_o  (count),
    .run_o    (run),
    .trig_o   (trig),
    .rdata_o  (reg_rdata_o)
  );

  cce_walker #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_en_i (master_en_i),
    .run_i       (run),
    .trig_i      (trig),
    .base_i      (base),
    .count_i     (count),
    .mem_ready_i (mem_ready_i),
    .start_o     (start),
    .finish_o    (finish),
    .active_o    (active),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/cce_checker.sv
module cce_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_we_o,
  input logic        mem_ready_i,
  input logic [23:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        done_o
);
  // R5
  addr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[1:0] == 2'b00);

  // R6
  chain_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_ready_i && mem_wdata_o != 32'h00FF_FFFF)
      |=> (mem_we_o && mem_addr_o == $past(mem_wdata_o[23:0])));

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_ready_i)
      |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R10
  done_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o && mem_ready_i && mem_wdata_o == 32'h00FF_FFFF));

  // R10
  end_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_ready_i && mem_wdata_o == 32'h00FF_FFFF) |=> (done_o && !mem_we_o));

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind chain_clear_engine cce_checker u_cce_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .done_o      (done_o)
);

// File: tb/chain_clear_engine_bench.sv
module chain_clear_engine_bench;
  localparam int unsigned AW = 12;
  localparam logic [23:0] SPACE = 24'h000FFF;
  localparam logic [23:0] ALIGN = 24'h000FFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        master_en = 1'b0;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        done;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  chain_clear_engine #(.MEM_AW(AW), .CNT_W(16)) u_chain_clear_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .master_en_i(master_en),
    .mem_ready_i(mem_ready), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_idle(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 if (mem_we) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  // Program (optionally), start, and check every write of one transfer.
  task automatic run(input logic [31:0] base, input logic [31:0] cnt, input bit stall,
                     input bit prog, input int inj_at, input logic [1:0] inj_a,
                     input logic [31:0] inj_d);
    int n, idx, waitc, bad, gaps;
    logic [23:0] e_addr, e_data, h_addr;
    logic [31:0] h_data;
    bit held, pend, inj_now;
    n = (cnt[15:0] == 16'd0) ? 65536 : int'(cnt[15:0]);
    if (prog) begin
      reg_wr(2'd0, base);
      reg_wr(2'd1, cnt);
      reg_wr(2'd2, 32'h3);
    end
    e_addr = base[23:0] & ALIGN;
    idx = 0; waitc = 0; bad = 0; gaps = 0; held = 0; pend = (inj_at >= 0);
    while (idx < n && waitc < 60) begin
      @(negedge clk);
      cyc++;
      reg_we = 1'b0; reg_addr = 2'd2;
      mem_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      inj_now = 0;
      if (pend && idx == inj_at) begin
        reg_we = 1'b1; reg_addr = inj_a; reg_wdata = inj_d; pend = 0; inj_now = 1;
      end
      #1;
      if (mem_we) begin
        if (idx == 0 && !held && !inj_now)
          // R4: trigger cleared, enable still set once writing starts
          check(reg_rdata[1:0] == 2'b01, "R4 ctrl at start", reg_rdata, 32'h1);
        if (held) begin
          check(mem_addr == h_addr && mem_wdata == h_data, "R9 stall hold",
                {mem_addr, mem_wdata}, {h_addr, h_data});
          held = 0;
        end
        if (mem_ready) begin
          e_data = (idx == n - 1) ? 24'hFFFFFF : ((e_addr - 24'd4) & SPACE);
          if (mem_addr != e_addr || mem_wdata != {8'h0, e_data}) begin
            if (bad == 0)
              check(0, "R5/R6/R7 write", {mem_addr, mem_wdata}, {e_addr, 8'h0, e_data});
            bad++;
          end
          e_addr = (e_addr - 24'd4) & ALIGN;
          idx++;
        end else begin
          held = 1; h_addr = mem_addr; h_data = mem_wdata;
        end
      end else begin
        if (idx > 0) gaps++;
        waitc++;
      end
    end
    mem_ready = 1'b1;
    check(bad == 0, "R5 R6 R7 chain contents", bad, 0);
    check(idx == n, "R7 R8 write count", idx, n);
    check(gaps == 0, "R12 no gap between writes", gaps, 0);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
    #1 check(done == 1'b1 && mem_we == 1'b0, "R10 done after last write", {done, mem_we}, 2'b10);
    @(negedge clk);
    #1 check(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] bases [5];
    bases[0] = 32'h0; bases[1] = 32'h4; bases[2] = 32'h13;
    bases[3] = 32'hFF_F008; bases[4] = 32'h800;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(2'd0, rd); check(rd == 0, "R1 start reg", rd, 0);
    reg_rd(2'd1, rd); check(rd == 0, "R1 count reg", rd, 0);
    reg_rd(2'd2, rd); check(rd == 0, "R1 ctrl reg", rd, 0);
    check(mem_we == 0 && done == 0, "R1 outputs", {mem_we, done}, 0);

    // R2 field widths
    reg_wr(2'd0, 32'hABCD_EF12);
    reg_rd(2'd0, rd); check(rd == 32'h00CD_EF12, "R2 start mask", rd, 32'h00CD_EF12);
    reg_wr(2'd1, 32'h1234_5678);
    reg_rd(2'd1, rd); check(rd == 32'h5678, "R2 count mask", rd, 32'h5678);
    reg_rd(2'd3, rd); check(rd == 0, "R2 select 3", rd, 0);
    reg_wr(2'd2, 32'hFFFF_FFF0);
    reg_rd(2'd2, rd); check(rd == 0, "R2 ctrl unused bits", rd, 0);

    // R3 gating
    reg_wr(2'd0, 32'h40);
    reg_wr(2'd1, 32'd5);
    reg_wr(2'd2, 32'h3);
    expect_idle(10, "R3 master off");
    reg_rd(2'd2, rd); check(rd == 32'h3, "R3 request held", rd, 32'h3);
    master_en = 1'b1;
    run(32'h40, 32'd5, 0, 0, -1, 2'd0, 0);
    reg_rd(2'd2, rd); check(rd == 0, "R4 ctrl after end", rd, 0);
    reg_wr(2'd2, 32'h1);
    expect_idle(10, "R3 trigger low");
    reg_wr(2'd2, 32'h2);
    expect_idle(10, "R3 enable low");
    reg_rd(2'd2, rd); check(rd == 32'h2, "R3 trigger kept", rd, 32'h2);

    // R5 R6 R7 R9 R12 sweep
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 5; b++)
        for (int c = 1; c <= 9; c++)
          run(bases[b], c, s[0], 1, -1, 2'd0, 0);

    // R8 full-length chain
    reg_wr(2'd1, 32'h1_0000);
    reg_rd(2'd1, rd); check(rd == 0, "R8 count reads zero", rd, 0);
    run(32'h100, 32'h0, 0, 1, -1, 2'd0, 0);

    // R11 control write mid-run: clear enable, set trigger
    run(32'h200, 32'd20, 0, 1, 5, 2'd2, 32'h2);
    reg_rd(2'd2, rd); check(rd == 32'h2, "R11 ctrl after run", rd, 32'h2);
    expect_idle(10, "R11 no restart");
    // R11 control write mid-run clearing both bits, with stalls
    run(32'h300, 32'd12, 1, 1, 3, 2'd2, 32'h0);
    reg_rd(2'd2, rd); check(rd == 0, "R11 ctrl cleared", rd, 0);
    // R11 start address and count rewritten mid-run
    run(32'h400, 32'd15, 0, 1, 4, 2'd0, 32'h123);
    reg_rd(2'd0, rd); check(rd == 32'h123, "R11 start reg updated", rd, 32'h123);
    run(32'h500, 32'd15, 0, 1, 2, 2'd1, 32'd3);
    reg_rd(2'd1, rd); check(rd == 32'd3, "R11 count reg updated", rd, 32'd3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule